// File: doc/BRIEF.md
# Admin Command Queue Engine

This block is the device side of a host-to-device management channel. The host keeps an array of fixed-size command slots in one memory page. It fills the next free slots, then writes its running total of submitted commands to a doorbell register. The engine sees that its executed total is behind the doorbell and works through the missing commands one at a time, in order. For each command it reads the opcode and argument words from the slot over a simple memory port, runs a stub executor, and writes a status word back into the same slot. Only then does it advance the executed total. The host polls that total until it matches what it wrote.

A base-frame register gives the page frame number of the slot array. Any write to it clears both running totals and abandons a command that is in progress. A value of zero also switches the engine off. Register data and slot words are big-endian on the wire, and the engine reverses the byte order on every access. Default geometry is a 4096-byte page of 64-byte slots, which gives 64 slots. The counter width, frame width, executor latency and status word position are parameters.

Top module: `admin_cmd_engine`

## Requirements
- R1: After reset, the base frame, doorbell and executed registers all read zero and no memory request is raised.
- R2: Register data on the bus is big-endian: the bus word is the byte-reversed register value, so an executed count of 1 reads back as 32'h0100_0000. Register read address 0 is the base frame, 1 is the doorbell and 2 is the executed count.
- R3: A write to the base frame (address 0) keeps the low PFN_W bits and sets both the doorbell and the executed count to zero, for any value written. It also abandons any in-flight command, and no later memory request is made for it.
- R4: While the base frame is zero, doorbell writes (address 1) are ignored, the doorbell reads zero and no memory request is made.
- R5: A doorbell value v is accepted only when (v - executed) mod 2^CNT_W lies in 1 .. 2^(CNT_W-1)-1. Any other value, including one equal to or behind the executed count, leaves the doorbell unchanged and the engine idle.
- R6: Command n uses slot n mod 64 at byte address frame*4096 + slot*64 + 4*word. The engine reads word 0 and then word 1, and writes only word STATUS_WORD (15, byte offset 60).
- R7: The opcode is word 0 and the argument is word 1, both big-endian. If the opcode is in 1..MAX_OP (7), the status is opcode + arg mod 2^32. Otherwise the status is 32'hFFFF_FFFF. The status is written big-endian.
- R8: The executed count rises by exactly one after each acknowledged status write. Commands run strictly one at a time and in order, and the count wraps modulo 2^CNT_W.
- R9: A memory request keeps its address and direction stable until it is acknowledged, unless a base-frame write abandons it.
- R10: The engine runs until the executed count equals the doorbell and then stays idle with no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Register write address |
| reg_wdata | input | 32 | Register write data, big-endian |
| reg_raddr | input | 2 | Register read address |
| reg_rdata | output | 32 | Register read data, big-endian, combinational |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | PFN_W+12 | Byte address of the word |
| mem_wdata | output | 32 | Write data, big-endian |
| mem_ack | input | 1 | Memory acknowledge; read data is valid in the same cycle |
| mem_rdata | input | 32 | Read data, big-endian |

## Verification
The bench builds the engine with CNT_W = 8 and EXEC_LAT = 3 and leaves the other parameters at their defaults. The narrow counter lets a few hundred commands carry both running totals through the 255-to-0 wrap and the slot index through several laps of the 64-slot page, so the modular doorbell window is tested across the wrap. With three executor cycles, a base-frame write can be made to land in the middle of a command, and random memory acknowledge delays hold requests open for several cycles.

// File: rtl/acq_pkg.sv
package acq_pkg;

   localparam logic [1:0] ACQ_REG_FRAME = 2'd0;
   localparam logic [1:0] ACQ_REG_BELL  = 2'd1;
   localparam logic [1:0] ACQ_REG_DONE  = 2'd2;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_FETCH,
      SQ_EXEC,
      SQ_STORE
   } acq_state_e;

   function automatic logic [31:0] acq_swap(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

endpackage

// File: rtl/acq_regs.sv
module acq_regs
   import acq_pkg::*;
#(
   parameter int PFN_W     = 20,
   parameter int CNT_W     = 32,
   parameter int SLOT_BITS = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [1:0]           reg_waddr,
   input  logic [31:0]          reg_wdata,
   input  logic [1:0]           reg_raddr,
   output logic [31:0]          reg_rdata,
   input  logic                 cmd_done,
   output logic [PFN_W-1:0]     frame,
   output logic [SLOT_BITS-1:0] slot_idx,
   output logic                 pending,
   output logic                 flush
);

   logic [CNT_W-1:0] bell_q;
   logic [CNT_W-1:0] done_q;
   logic [CNT_W-1:0] bell_new;
   logic [CNT_W-1:0] lead;
   logic             enabled;
   logic             bell_wr;
   logic             bell_ok;

   assign enabled  = (frame != '0);
   assign flush    = reg_wr && (reg_waddr == ACQ_REG_FRAME);
   assign bell_new = CNT_W'(acq_swap(reg_wdata));
   assign lead     = bell_new - done_q;
   assign bell_ok  = (lead != '0) && !lead[CNT_W-1];
   assign bell_wr  = reg_wr && (reg_waddr == ACQ_REG_BELL) && enabled;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame  <= '0;
         bell_q <= '0;
         done_q <= '0;
      end else if (flush) begin
         frame  <= PFN_W'(acq_swap(reg_wdata));
         bell_q <= '0;
         done_q <= '0;
      end else begin
         if (cmd_done) done_q <= done_q + 1'b1;
         if (bell_wr && bell_ok) bell_q <= bell_new;
      end
   end

   assign pending  = enabled && (bell_q != done_q);
   assign slot_idx = done_q[SLOT_BITS-1:0];

   always_comb begin
      unique case (reg_raddr)
         ACQ_REG_FRAME: reg_rdata = acq_swap(32'(frame));
         ACQ_REG_BELL:  reg_rdata = acq_swap(32'(bell_q));
         ACQ_REG_DONE:  reg_rdata = acq_swap(32'(done_q));
         default:       reg_rdata = '0;
      endcase
   end

   // R8: the executed count moves by exactly one per completion
   assert_done_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_done && !flush) |=> (done_q == $past(done_q) + 1'b1));

   // R3: without a completion or a frame write the count holds
   assert_done_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_done && !flush) |=> $stable(done_q));

   // R10: a completion only happens while work is owed
   assert_done_owed_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |-> pending);

   // R4: a disabled engine never takes a doorbell
   assert_bell_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!enabled && !flush) |=> (bell_q == '0));

endmodule

// File: rtl/acq_exec.sv
module acq_exec #(
   parameter int EXEC_LAT = 2,
   parameter int MAX_OP   = 7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        go,
   input  logic [31:0] opcode,
   input  logic [31:0] arg,
   output logic        done,
   output logic [31:0] status
);

   logic known;

   assign known  = (opcode != 32'd0) && (opcode <= 32'(MAX_OP));
   assign status = known ? (opcode + arg) : 32'hFFFF_FFFF;

   generate
      if (EXEC_LAT == 0) begin : g_instant
         assign done = go;
      end else begin : g_timed
         localparam int LAT_W = $clog2(EXEC_LAT + 1);
         logic [LAT_W-1:0] wait_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   wait_q <= '0;
            else if (!go) wait_q <= '0;
            else          wait_q <= wait_q + 1'b1;
         end

         assign done = go && (wait_q == LAT_W'(EXEC_LAT));

         // R7: the executor never reports before its latency has elapsed
         assert_exec_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (go && !$past(go)) |-> !done);
      end
   endgenerate

endmodule

// File: rtl/acq_seq.sv
module acq_seq
   import acq_pkg::*;
#(
   parameter int PFN_W       = 20,
   parameter int SLOT_BITS   = 6,
   parameter int WORD_BITS   = 4,
   parameter int STATUS_WORD = 15,
   localparam int MEM_AW     = PFN_W + SLOT_BITS + WORD_BITS + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 flush,
   input  logic                 pending,
   input  logic [PFN_W-1:0]     frame,
   input  logic [SLOT_BITS-1:0] slot_idx,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [MEM_AW-1:0]    mem_addr,
   output logic [31:0]          mem_wdata,
   input  logic                 mem_ack,
   input  logic [31:0]          mem_rdata,
   output logic                 exe_go,
   output logic [31:0]          opcode,
   output logic [31:0]          arg,
   input  logic                 exe_done,
   input  logic [31:0]          exe_status,
   output logic                 cmd_done
);

   acq_state_e           state_q;
   logic                 second_q;
   logic [31:0]          status_q;
   logic [WORD_BITS-1:0] word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         second_q <= 1'b0;
         opcode   <= '0;
         arg      <= '0;
         status_q <= '0;
      end else if (flush) begin
         state_q  <= SQ_IDLE;
         second_q <= 1'b0;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               second_q <= 1'b0;
               if (pending) state_q <= SQ_FETCH;
            end
            SQ_FETCH: begin
               if (mem_ack) begin
                  if (!second_q) begin
                     opcode   <= acq_swap(mem_rdata);
                     second_q <= 1'b1;
                  end else begin
                     arg     <= acq_swap(mem_rdata);
                     state_q <= SQ_EXEC;
                  end
               end
            end
            SQ_EXEC: begin
               if (exe_done) begin
                  status_q <= exe_status;
                  state_q  <= SQ_STORE;
               end
            end
            SQ_STORE: begin
               if (mem_ack) state_q <= SQ_IDLE;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      word = WORD_BITS'(STATUS_WORD);
      if (state_q == SQ_FETCH) word = WORD_BITS'(second_q);
   end

   assign mem_req   = (state_q == SQ_FETCH) || (state_q == SQ_STORE);
   assign mem_we    = (state_q == SQ_STORE);
   assign mem_addr  = {frame, slot_idx, word, 2'b00};
   assign mem_wdata = acq_swap(status_q);
   assign exe_go    = (state_q == SQ_EXEC);
   assign cmd_done  = (state_q == SQ_STORE) && mem_ack && !flush;

   // R9: an open request keeps its address and direction
   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !flush) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R6: writes only ever target the status word
   assert_store_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_addr[WORD_BITS+1:2] == WORD_BITS'(STATUS_WORD)));

   // R4: a zero frame means no memory traffic
   assert_quiet_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame == '0) |-> !mem_req);

   // R3: a frame write closes any request on the next cycle
   assert_flush_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !mem_req);

endmodule

// File: rtl/admin_cmd_engine.sv
module admin_cmd_engine
   import acq_pkg::*;
#(
   parameter int PAGE_BYTES  = 4096,
   parameter int SLOT_BYTES  = 64,
   parameter int STATUS_WORD = 15,
   parameter int PFN_W       = 20,
   parameter int CNT_W       = 32,
   parameter int EXEC_LAT    = 2,
   parameter int MAX_OP      = 7,
   localparam int PAGE_BITS  = $clog2(PAGE_BYTES),
   localparam int MEM_AW     = PFN_W + PAGE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_waddr,
   input  logic [31:0]       reg_wdata,
   input  logic [1:0]        reg_raddr,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata
);

   localparam int SLOT_BITS = $clog2(PAGE_BYTES / SLOT_BYTES);
   localparam int WORD_BITS = $clog2(SLOT_BYTES / 4);

   generate
      if ((1 << PAGE_BITS) != PAGE_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
      if ((SLOT_BYTES < 8) || ((1 << $clog2(SLOT_BYTES)) != SLOT_BYTES) ||
          (SLOT_BYTES > PAGE_BYTES)) begin : g_bad_slot
         $error("SLOT_BYTES must be a power of two between 8 and PAGE_BYTES");
      end
      if ((STATUS_WORD < 2) || (STATUS_WORD >= SLOT_BYTES / 4)) begin : g_bad_status
         $error("STATUS_WORD must lie past the fetched words and inside a slot");
      end
      if ((CNT_W <= SLOT_BITS) || (CNT_W > 32)) begin : g_bad_cnt
         $error("CNT_W must exceed the slot index width and fit a register");
      end
      if ((PFN_W < 1) || (PFN_W > 32)) begin : g_bad_pfn
         $error("PFN_W must be 1 to 32");
      end
      if (EXEC_LAT < 0) begin : g_bad_lat
         $error("EXEC_LAT must not be negative");
      end
   endgenerate

   logic [PFN_W-1:0]     frame;
   logic [SLOT_BITS-1:0] slot_idx;
   logic                 pending;
   logic                 flush;
   logic                 cmd_done;
   logic                 exe_go;
   logic                 exe_done;
   logic [31:0]          opcode;
   logic [31:0]          arg;
   logic [31:0]          exe_status;

   acq_regs #(
      .PFN_W     (PFN_W),
      .CNT_W     (CNT_W),
      .SLOT_BITS (SLOT_BITS)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_waddr (reg_waddr),
      .reg_wdata (reg_wdata),
      .reg_raddr (reg_raddr),
      .reg_rdata (reg_rdata),
      .cmd_done  (cmd_done),
      .frame     (frame),
      .slot_idx  (slot_idx),
      .pending   (pending),
      .flush     (flush)
   );

   acq_seq #(
      .PFN_W       (PFN_W),
      .SLOT_BITS   (SLOT_BITS),
      .WORD_BITS   (WORD_BITS),
      .STATUS_WORD (STATUS_WORD)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .pending    (pending),
      .frame      (frame),
      .slot_idx   (slot_idx),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .exe_go     (exe_go),
      .opcode     (opcode),
      .arg        (arg),
      .exe_done   (exe_done),
      .exe_status (exe_status),
      .cmd_done   (cmd_done)
   );

   acq_exec #(
      .EXEC_LAT (EXEC_LAT),
      .MAX_OP   (MAX_OP)
   ) u_exec (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (exe_go),
      .opcode (opcode),
      .arg    (arg),
      .done   (exe_done),
      .status (exe_status)
   );

endmodule

// File: tb/sim_admin_cmd_engine.sv
module sim_admin_cmd_engine;

   localparam int CNT_W    = 8;
   localparam int EXEC_LAT = 3;
   localparam int MAX_OP   = 7;
   localparam int PFN_W    = 20;
   localparam int MEM_AW   = PFN_W + 12;
   localparam int CMOD     = 1 << CNT_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [1:0]        reg_waddr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [1:0]        reg_raddr = '0;
   logic [31:0]       reg_rdata;
   logic              mem_req;
   logic              mem_we;
   logic [MEM_AW-1:0] mem_addr;
   logic [31:0]       mem_wdata;
   logic              mem_ack = 1'b0;
   logic [31:0]       mem_rdata = '0;

   admin_cmd_engine #(
      .PFN_W    (PFN_W),
      .CNT_W    (CNT_W),
      .EXEC_LAT (EXEC_LAT),
      .MAX_OP   (MAX_OP)
   ) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_waddr (reg_waddr),
      .reg_wdata (reg_wdata),
      .reg_raddr (reg_raddr),
      .reg_rdata (reg_rdata),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   logic [31:0] mem [0:2047];
   int          frame_cur = 0;
   int          exp_slot = 0;
   int          rd_phase = 0;
   int          total = 0;
   logic [31:0] op_arr [0:63];
   logic [31:0] arg_arr [0:63];

   bit              req_seen = 0;
   logic [MEM_AW-1:0] first_addr;
   int              wait_left = 0;

   function automatic logic [31:0] swap(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   function automatic logic [31:0] want_status(input logic [31:0] op, input logic [31:0] a);
      if (op >= 1 && op <= MAX_OP) return op + a;
      return 32'hFFFF_FFFF;
   endfunction

   function automatic int midx(input int fr, input int slot, input int word);
      return ((fr & 1) << 10) | ((slot & 63) << 4) | (word & 15);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory model and traffic monitor
   always @(negedge clk) begin
      mem_ack = 1'b0;
      if (mem_req) begin
         if (!req_seen) begin
            req_seen   = 1;
            first_addr = mem_addr;
            wait_left  = $urandom % 4;
         end else if (mem_addr != first_addr) begin
            chk(0, "R9 address moved", 32'(mem_addr), 32'(first_addr));
         end
         if (wait_left == 0) begin
            mem_ack  = 1'b1;
            req_seen = 0;
            chk(mem_addr[31:12] == 20'(frame_cur) && mem_addr[11:6] == 6'(exp_slot),
                "R6 frame/slot", 32'(mem_addr), 32'((frame_cur << 12) | (exp_slot << 6)));
            if (mem_we) begin
               chk(mem_addr[5:2] == 4'd15, "R6 store word", 32'(mem_addr[5:2]), 32'd15);
               mem[midx(int'(mem_addr[12]), int'(mem_addr[11:6]), int'(mem_addr[5:2]))] = mem_wdata;
               exp_slot = (exp_slot + 1) % 64;
               rd_phase = 0;
            end else begin
               chk(int'(mem_addr[5:2]) == rd_phase, "R6 fetch order", 32'(mem_addr[5:2]), 32'(rd_phase));
               mem_rdata = mem[midx(int'(mem_addr[12]), int'(mem_addr[11:6]), int'(mem_addr[5:2]))];
               rd_phase  = rd_phase ^ 1;
            end
         end else begin
            wait_left--;
         end
      end else begin
         req_seen = 0;
      end
   end

   task automatic reg_write(input logic [1:0] a, input logic [31:0] v);
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_waddr = a;
      reg_wdata = swap(v);
      @(posedge clk);
      #1;
      reg_wr = 1'b0;
      if (a == 2'd0) begin
         frame_cur = int'(v & 32'h000F_FFFF);
         exp_slot  = 0;
         rd_phase  = 0;
         total     = 0;
      end
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_raddr = a;
      #1;
      v = swap(reg_rdata);
   endtask

   task automatic put_cmd(input int slot, input logic [31:0] op, input logic [31:0] a);
      op_arr[slot]  = op;
      arg_arr[slot] = a;
      mem[midx(frame_cur, slot, 0)]  = swap(op);
      mem[midx(frame_cur, slot, 1)]  = swap(a);
      mem[midx(frame_cur, slot, 15)] = 32'hDEAD_BEEF;
   endtask

   task automatic expect_quiet(input int n, input string tag);
      bit seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #2;
         if (mem_req) seen = 1;
      end
      chk(!seen, tag, 32'(seen), 32'd0);
   endtask

   task automatic run_batch(input int n);
      logic [31:0] v;
      int first = total;
      bit hit = 0;
      for (int i = 0; i < n; i++)
         put_cmd((first + i) % 64, 32'($urandom % 10), $urandom);
      total = first + n;
      reg_write(2'd1, 32'(total % CMOD));
      for (int k = 0; k < 3000 && !hit; k++) begin
         reg_read(2'd2, v);
         if (v == 32'(total % CMOD)) hit = 1;
      end
      chk(hit, "R8 executed reaches doorbell", v, 32'(total % CMOD));
      for (int i = 0; i < n; i++) begin
         int s = (first + i) % 64;
         logic [31:0] got = swap(mem[midx(frame_cur, s, 15)]);
         chk(got == want_status(op_arr[s], arg_arr[s]), "R7 status word", got,
             want_status(op_arr[s], arg_arr[s]));
      end
      expect_quiet(4, "R10 idle after catching up");
   endtask

   task automatic bad_bell(input int lead);
      logic [31:0] b0, b1, d1;
      reg_read(2'd1, b0);
      reg_write(2'd1, 32'((total + lead) % CMOD));
      reg_read(2'd1, b1);
      reg_read(2'd2, d1);
      chk(b1 == b0, "R5 rejected doorbell kept", b1, b0);
      chk(d1 == 32'(total % CMOD), "R5 executed unchanged", d1, 32'(total % CMOD));
      expect_quiet(5, "R5 no traffic after rejected doorbell");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd4711));
      for (int i = 0; i < 2048; i++) mem[i] = '0;
      repeat (4) @(posedge clk);
      rst_n = 1'b1;

      // R1 reset state
      reg_read(2'd0, v); chk(v == 0, "R1 frame after reset", v, 0);
      reg_read(2'd1, v); chk(v == 0, "R1 doorbell after reset", v, 0);
      reg_read(2'd2, v); chk(v == 0, "R1 executed after reset", v, 0);
      chk(!mem_req, "R1 no request after reset", 32'(mem_req), 0);

      // R4 doorbell while disabled
      reg_write(2'd1, 32'd3);
      reg_read(2'd1, v); chk(v == 0, "R4 doorbell ignored when off", v, 0);
      expect_quiet(6, "R4 no traffic when off");

      // enable on frame 1, single directed command
      reg_write(2'd0, 32'd1);
      reg_read(2'd0, v); chk(v == 1, "R3 frame stored", v, 1);
      put_cmd(0, 32'd2, 32'h10);
      total = 1;
      reg_write(2'd1, 32'd1);
      repeat (40) @(posedge clk);
      chk(swap(mem[midx(1, 0, 15)]) == 32'h12, "R7 directed status", swap(mem[midx(1, 0, 15)]), 32'h12);
      @(negedge clk); reg_raddr = 2'd2; #1;
      chk(reg_rdata == 32'h0100_0000, "R2 raw executed byte order", reg_rdata, 32'h0100_0000);
      reg_raddr = 2'd0; #1;
      chk(reg_rdata == 32'h0100_0000, "R2 raw frame byte order", reg_rdata, 32'h0100_0000);

      // random batches through counter and slot wrap
      while (total < 330) begin
         run_batch(1 + ($urandom % 20));
         case ($urandom % 4)
            0: bad_bell(0);
            1: bad_bell(CMOD - 1 - int'($urandom % 127));
            2: bad_bell(CMOD / 2);
            default: ;
         endcase
      end
      reg_read(2'd2, v);
      chk(v == 32'(total % CMOD), "R8 executed wrapped modulo", v, 32'(total % CMOD));

      // R3 abort mid-run with a wide value
      for (int i = 0; i < 10; i++) put_cmd((total + i) % 64, 32'd1, 32'(i));
      reg_write(2'd1, 32'((total + 10) % CMOD));
      repeat (7) @(posedge clk);
      reg_write(2'd0, 32'hFFF0_0002);
      reg_read(2'd0, v); chk(v == 2, "R3 frame truncated", v, 2);
      reg_read(2'd1, v); chk(v == 0, "R3 doorbell cleared", v, 0);
      reg_read(2'd2, v); chk(v == 0, "R3 executed cleared", v, 0);
      expect_quiet(12, "R3 abandoned command stops");

      run_batch(3);
      reg_write(2'd0, 32'd2);
      reg_read(2'd2, v); chk(v == 0, "R3 rewrite same frame clears count", v, 0);
      run_batch(5);

      // disable again
      reg_write(2'd0, 32'd0);
      reg_read(2'd0, v); chk(v == 0, "R3 frame zero", v, 0);
      reg_write(2'd1, 32'd2);
      reg_read(2'd1, v); chk(v == 0, "R4 doorbell ignored after disable", v, 0);
      expect_quiet(6, "R4 quiet after disable");

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule